// File: doc/BRIEF.md
# Bounded-Response Edge Monitor

This block is a synthesizable checker for a single timing rule between two 1-bit signals, called the trigger and the response. Both signals are sampled on the rising clock edge. Each signal has its own polarity select, so a rule can be built from any pairing of rising and falling edges. Every trigger edge opens an attempt. The attempt succeeds if a response edge follows between `win_lo` and `win_hi` cycles later, counting both ends. If the window closes with no response edge, the attempt fails.

Attempts are held in an aging bit vector, one bit for each possible age. Triggers that arrive while older attempts are still open are judged on their own windows and never merge with them. Each signal has a valid input that marks its sample as known. A transition counts as an edge only when the sample is valid in both the previous and the current cycle. The monitor has one control input, its own synchronous clear. Nothing else cancels a pending attempt. The outputs are a one-cycle fail pulse, a sticky flag that records any failure, and a saturating count of failures.

Top module: `edge_resp_monitor`

## Requirements
- R1: For each signal, the polarity input selects which edge qualifies: 1 selects a rise (0 in the previous sample, 1 in the current one) and 0 selects a fall (1 then 0). An edge of the other direction has no effect.
- R2: When the response edge is sampled d cycles after the trigger edge, with win_lo <= d <= win_hi, the attempt completes and no failure is reported.
- R3: An attempt fails if it receives no qualifying response edge inside its window. This covers a response that comes too early, one that comes too late and one that never comes.
- R4: `fail_pulse` is high for exactly one cycle. It becomes visible just after the clock edge that lies win_hi edges after the trigger edge.
- R5: A second trigger edge while an earlier attempt is pending opens a separate attempt. Each attempt is judged on its own window.
- R6: A single response edge completes every pending attempt whose age is inside the window. An attempt younger than win_lo is left pending.
- R7: A transition is ignored as a trigger or as a response unless the signal's valid input was high in both the previous and the current sample.
- R8: `fail_sticky` rises with the first failure and stays high until `clr`.
- R9: `fail_count` increases by one for each failed attempt and saturates at 2^CNT_W-1.
- R10: A synchronous `clr` discards every pending attempt and forgets the previous samples. It sets the pulse, the sticky flag and the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| clr | input | 1 | Synchronous active-high clear of the monitor |
| trig_sig | input | 1 | Trigger signal |
| trig_known | input | 1 | Trigger sample is a known value |
| trig_pol | input | 1 | Trigger edge: 1 rise, 0 fall |
| resp_sig | input | 1 | Response signal |
| resp_known | input | 1 | Response sample is a known value |
| resp_pol | input | 1 | Response edge: 1 rise, 0 fall |
| win_lo | input | $clog2(HI_MAX+1) | Earliest accepted response delay, at least 1 |
| win_hi | input | $clog2(HI_MAX+1) | Latest accepted response delay, at most HI_MAX |
| fail_pulse | output | 1 | One-cycle pulse per failed attempt |
| fail_sticky | output | 1 | At least one failure since clear |
| fail_count | output | CNT_W | Saturating count of failures |

## Verification
The hardest case to reach from the ports is overlapping attempts that one response edge treats differently. To build it, the trigger is raised, dropped and raised again two cycles later, so that two attempts are open at ages two apart. The response edge is then placed where the older attempt is inside the window and the younger one is not. The bench checks that the pulse appears only at the younger attempt's deadline. It also uses a wider window that takes in both attempts and checks that no pulse appears. Saturation is reached with a narrow counter parameter and a trigger that toggles on every other cycle.

// File: rtl/edge_mon_pkg.sv
package edge_mon_pkg;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic last_val;
        logic last_known;
    } edge_hist_t;

endpackage

// File: rtl/emon_edge_detect.sv
module emon_edge_detect
    import edge_mon_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic sig,
    input  logic known,
    input  logic pol,
    output logic edge_o
);

    edge_hist_t hist_d, hist_q;
    logic       is_rise, is_fall;

    always_comb begin
        is_rise = hist_q.last_known && known && !hist_q.last_val && sig;
        is_fall = hist_q.last_known && known && hist_q.last_val && !sig;
        edge_o  = (edge_pol_e'(pol) == POL_RISE) ? is_rise : is_fall;

        hist_d.last_val   = sig;
        hist_d.last_known = known;
        if (clr) begin
            hist_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hist_q <= hist_d;
    end

endmodule

// File: rtl/emon_age_vector.sv
module emon_age_vector #(
    parameter int HI_MAX = 16,
    localparam int WIN_W = $clog2(HI_MAX + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             trig,
    input  logic             resp,
    input  logic [WIN_W-1:0] lo,
    input  logic [WIN_W-1:0] hi,
    output logic             expire_o
);

    typedef struct packed {
        logic [HI_MAX-1:0] age;
    } age_state_t;

    age_state_t        st_d, st_q;
    logic [HI_MAX-1:0] in_win;
    logic [HI_MAX-1:0] live;
    logic [HI_MAX-1:0] at_end;

    // bit k-1 of the vector stands for an attempt that is k cycles old
    always_comb begin
        for (int k = 1; k <= HI_MAX; k++) begin
            in_win[k-1] = (k >= int'(lo)) && (k <= int'(hi));
            live[k-1]   = st_q.age[k-1] && !(resp && in_win[k-1]);
            at_end[k-1] = (k == int'(hi));
        end

        expire_o   = |(live & at_end);

        st_d.age    = '0;
        st_d.age[0] = trig;
        for (int k = 1; k < HI_MAX; k++) begin
            st_d.age[k] = live[k-1] && (k < int'(hi));
        end

        if (clr) begin
            st_d     = '0;
            expire_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/emon_fail_accum.sv
module emon_fail_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             expire,
    output logic             pulse_o,
    output logic             sticky_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic             pulse;
        logic             sticky;
        logic [CNT_W-1:0] count;
    } acc_state_t;

    acc_state_t acc_d, acc_q;

    always_comb begin
        acc_d.pulse  = expire;
        acc_d.sticky = acc_q.sticky || expire;
        acc_d.count  = acc_q.count;
        if (expire && (acc_q.count != '1)) begin
            acc_d.count = acc_q.count + CNT_W'(1);
        end
        if (clr) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign pulse_o  = acc_q.pulse;
    assign sticky_o = acc_q.sticky;
    assign count_o  = acc_q.count;

endmodule

// File: rtl/edge_resp_monitor.sv
module edge_resp_monitor #(
    parameter int HI_MAX = 16,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         clr,
    input  logic                         trig_sig,
    input  logic                         trig_known,
    input  logic                         trig_pol,
    input  logic                         resp_sig,
    input  logic                         resp_known,
    input  logic                         resp_pol,
    input  logic [$clog2(HI_MAX+1)-1:0]  win_lo,
    input  logic [$clog2(HI_MAX+1)-1:0]  win_hi,
    output logic                         fail_pulse,
    output logic                         fail_sticky,
    output logic [CNT_W-1:0]             fail_count
);

    localparam int NSIG = 2;

    logic [NSIG-1:0] sig_v, known_v, pol_v, edge_v;
    logic            expire;

    assign sig_v   = {resp_sig,   trig_sig};
    assign known_v = {resp_known, trig_known};
    assign pol_v   = {resp_pol,   trig_pol};

    for (genvar i = 0; i < NSIG; i++) begin : g_edge
        emon_edge_detect u_edge (
            .clk    (clk),
            .clr    (clr),
            .sig    (sig_v[i]),
            .known  (known_v[i]),
            .pol    (pol_v[i]),
            .edge_o (edge_v[i])
        );
    end

    emon_age_vector #(.HI_MAX(HI_MAX)) u_age (
        .clk      (clk),
        .clr      (clr),
        .trig     (edge_v[0]),
        .resp     (edge_v[1]),
        .lo       (win_lo),
        .hi       (win_hi),
        .expire_o (expire)
    );

    emon_fail_accum #(.CNT_W(CNT_W)) u_acc (
        .clk      (clk),
        .clr      (clr),
        .expire   (expire),
        .pulse_o  (fail_pulse),
        .sticky_o (fail_sticky),
        .count_o  (fail_count)
    );

endmodule

// File: rtl/emon_checker.sv
module emon_checker #(
    parameter int HI_MAX = 16,
    parameter int CNT_W  = 16
) (
    input logic                        clk,
    input logic                        clr,
    input logic [$clog2(HI_MAX+1)-1:0] win_lo,
    input logic [$clog2(HI_MAX+1)-1:0] win_hi,
    input logic                        fail_pulse,
    input logic                        fail_sticky,
    input logic [CNT_W-1:0]            fail_count
);

    // R4: triggers are at least two cycles apart, so pulses never touch
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (clr)
        fail_pulse |=> !fail_pulse);

    // R8: a failure always shows in the sticky flag
    p_pulse_sets_sticky_r8: assert property (@(posedge clk) disable iff (clr)
        fail_pulse |-> fail_sticky);

    // R8: the sticky flag only drops through clr
    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (clr)
        fail_sticky |=> fail_sticky);

    // R9: below saturation the count follows the pulses exactly
    p_count_tracks_r9: assert property (@(posedge clk) disable iff (clr)
        (fail_count != '1) |=> (fail_count == $past(fail_count) + CNT_W'(fail_pulse)));

    // R9: a saturated count stays put
    p_count_saturates_r9: assert property (@(posedge clk) disable iff (clr)
        (fail_count == '1) |=> (fail_count == '1));

    // R2: window bounds stay legal while the monitor runs
    p_window_legal_r2: assert property (@(posedge clk) disable iff (clr)
        (win_lo != '0) && (win_lo <= win_hi) && (int'(win_hi) <= HI_MAX));

endmodule

bind edge_resp_monitor emon_checker #(.HI_MAX(HI_MAX), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .clr         (clr),
    .win_lo      (win_lo),
    .win_hi      (win_hi),
    .fail_pulse  (fail_pulse),
    .fail_sticky (fail_sticky),
    .fail_count  (fail_count)
);

// File: tb/tb_edge_resp_monitor.sv
module tb_edge_resp_monitor;

    localparam int HI_MAX = 16;
    localparam int CNT_W  = 4;
    localparam int WIN_W  = $clog2(HI_MAX + 1);
    localparam int NROW   = 9;

    typedef struct packed {
        logic             apol;
        logic             cpol;
        logic [WIN_W-1:0] lo;
        logic [WIN_W-1:0] hi;
        logic [WIN_W-1:0] d;     // response delay, 0 = never
        logic             fail;
    } row_t;

    localparam row_t TBL [NROW] = '{
        '{1'b1, 1'b1, 5'd1,  5'd3,  5'd2,  1'b0},
        '{1'b1, 1'b1, 5'd1,  5'd3,  5'd3,  1'b0},
        '{1'b1, 1'b1, 5'd1,  5'd3,  5'd4,  1'b1},
        '{1'b1, 1'b0, 5'd2,  5'd5,  5'd1,  1'b1},
        '{1'b0, 1'b1, 5'd2,  5'd5,  5'd2,  1'b0},
        '{1'b0, 1'b0, 5'd10, 5'd15, 5'd12, 1'b0},
        '{1'b0, 1'b0, 5'd10, 5'd15, 5'd0,  1'b1},
        '{1'b1, 1'b1, 5'd16, 5'd16, 5'd16, 1'b0},
        '{1'b1, 1'b1, 5'd4,  5'd4,  5'd3,  1'b1}
    };

    logic             clk = 1'b0;
    logic             clr = 1'b1;
    logic             a = 1'b0, a_k = 1'b1, a_p = 1'b1;
    logic             c = 1'b0, c_k = 1'b1, c_p = 1'b1;
    logic [WIN_W-1:0] lo = 5'd1, hi = 5'd1;
    logic             fail_pulse, fail_sticky;
    logic [CNT_W-1:0] fail_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    edge_resp_monitor #(.HI_MAX(HI_MAX), .CNT_W(CNT_W)) dut (
        .clk(clk), .clr(clr),
        .trig_sig(a), .trig_known(a_k), .trig_pol(a_p),
        .resp_sig(c), .resp_known(c_k), .resp_pol(c_p),
        .win_lo(lo), .win_hi(hi),
        .fail_pulse(fail_pulse), .fail_sticky(fail_sticky), .fail_count(fail_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input logic av, input logic cv);
        @(negedge clk);
        a = av;
        c = cv;
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic do_clr(input logic av, input logic cv);
        @(negedge clk);
        clr = 1'b1;
        a = av;
        c = cv;
        @(posedge clk);
        #1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_clr(1'b0, 1'b0);
        // R10: reset state
        check("R10 pulse", int'(fail_pulse), 0);
        check("R10 sticky", int'(fail_sticky), 0);
        check("R10 count", int'(fail_count), 0);

        // table walk: R1 R2 R3 R4
        for (int r = 0; r < NROW; r++) begin
            logic ai, aa, ci, ca;
            a_p = TBL[r].apol; c_p = TBL[r].cpol;
            lo  = TBL[r].lo;   hi  = TBL[r].hi;
            ai = !a_p; aa = a_p; ci = !c_p; ca = c_p;
            do_clr(ai, ci);
            step(ai, ci);
            step(ai, ci);
            step(aa, ci);
            for (int j = 1; j <= int'(hi) + 2; j++) begin
                step(aa, (TBL[r].d != 0 && j >= int'(TBL[r].d)) ? ca : ci);
                if (j == int'(hi))
                    check(TBL[r].fail ? "R3 pulse at deadline" : "R2 no pulse", int'(fail_pulse), int'(TBL[r].fail));
                else
                    check("R4 pulse off-deadline", int'(fail_pulse), 0);
            end
            check("R1/R3 sticky", int'(fail_sticky), int'(TBL[r].fail));
            check("R9 count", int'(fail_count), int'(TBL[r].fail));
        end

        // R5: overlapping attempts, only the younger fails
        a_p = 1'b1; c_p = 1'b1; lo = 5'd2; hi = 5'd4;
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
        step(1'b1, 1'b1); check("R5 older met", int'(fail_pulse), 0);
        step(1'b1, 1'b1); check("R5 gap", int'(fail_pulse), 0);
        step(1'b1, 1'b1); check("R5 younger fails", int'(fail_pulse), 1);
        check("R5 count", int'(fail_count), 1);

        // R6: one response edge closes both attempts
        lo = 5'd1; hi = 5'd4;
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
        for (int j = 0; j < 6; j++) step(1'b1, 1'b1);
        check("R6 both met", int'(fail_sticky), 0);

        // R7: trigger from unknown is not an edge
        lo = 5'd1; hi = 5'd2;
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0);
        a_k = 1'b0; step(1'b0, 1'b0);
        a_k = 1'b1; step(1'b1, 1'b0);
        for (int j = 0; j < 4; j++) step(1'b1, 1'b0);
        check("R7 trigger gated", int'(fail_sticky), 0);

        // R7: response from unknown does not satisfy
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        c_k = 1'b0; step(1'b1, 1'b0);
        c_k = 1'b1; step(1'b1, 1'b1);
        check("R7 response gated", int'(fail_pulse), 1);

        // R8: sticky holds, pulse drops
        for (int j = 0; j < 5; j++) step(1'b1, 1'b1);
        check("R8 sticky held", int'(fail_sticky), 1);
        check("R8 pulse low", int'(fail_pulse), 0);

        // R10: clr drops a pending attempt
        lo = 5'd1; hi = 5'd3;
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        do_clr(1'b1, 1'b0);
        for (int j = 0; j < 5; j++) step(1'b1, 1'b0);
        check("R10 pending dropped", int'(fail_sticky), 0);
        check("R10 count zero", int'(fail_count), 0);

        // R1: a rise does not trigger a fall rule
        a_p = 1'b0; lo = 5'd1; hi = 5'd2;
        do_clr(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        for (int j = 0; j < 4; j++) step(1'b1, 1'b0);
        check("R1 wrong direction", int'(fail_sticky), 0);

        // R9: saturation
        a_p = 1'b1; lo = 5'd1; hi = 5'd1;
        do_clr(1'b0, 1'b0);
        for (int j = 0; j < 3; j++) begin step(1'b0, 1'b0); step(1'b1, 1'b0); end
        step(1'b0, 1'b0);
        check("R9 three fails", int'(fail_count), 3);
        for (int j = 0; j < 20; j++) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
        step(1'b0, 1'b0);
        check("R9 saturated", int'(fail_count), 15);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule